// File: doc/BRIEF.md
# Bit-Time Timestamp Counter

This block keeps a 16-bit free-running timestamp whose unit is the nominal bit time of a CAN controller. It takes a one-cycle tick from the bit-timing logic and passes it through a prescaler that divides the tick rate by 1, 2, 4 or 8. The divided ticks advance the counter, which wraps around and never stops. The live count is always visible at the ports.

Two registers sample the count. A capture register takes the count when the protocol engine reports a frame received without error. It raises a one-cycle valid strobe so that a receive slot can store the value. A read register takes the count when a read is requested, so a host access returns the time at that moment. Producing the tick from the bit-timing settings is outside this block, and so is the slot storage.

Top module: `bit_stamp_top`

## Requirements
- R1: While `rst` is high at a clock edge, the count, the captured value, the read value and the capture strobe are all cleared to zero after that edge, and the prescaler phase and its remembered select return to zero.
- R2: With `div_sel_i` = 2'b00 (divide by 1) and the same select as in the previous cycle, each cycle with `bit_tick_i` high adds one to `stamp_o` at that edge. A cycle without a tick leaves `stamp_o` unchanged.
- R3: Select 2'b01 divides by 2, 2'b10 by 4 and 2'b11 by 8. With the select held, `stamp_o` advances on the Nth, 2Nth, 3Nth tick counted from the last prescaler restart.
- R4: A cycle whose `div_sel_i` differs from its value in the previous cycle (taken as 2'b00 after reset) restarts the prescaler phase at zero, and a tick in that cycle does not advance the count.
- R5: An advance from 16'hFFFF gives 16'h0000, and counting continues from there.
- R6: When `rx_ok_i` is high at an edge, after that edge `cap_stamp_o` holds the value `stamp_o` had before that edge, and `cap_valid_o` is high for exactly that one cycle.
- R7: In a cycle following an edge without `rx_ok_i`, `cap_valid_o` is low and `cap_stamp_o` keeps its previous value.
- R8: When a capture and a count advance fall on the same edge, the captured value is the count before the increment.
- R9: When `rd_req_i` is high at an edge, `rd_stamp_o` takes the value `stamp_o` had before that edge. Otherwise `rd_stamp_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick_i | input | 1 | One-cycle pulse per nominal bit time |
| div_sel_i | input | 2 | Prescale select: 00 /1, 01 /2, 10 /4, 11 /8 |
| rx_ok_i | input | 1 | Successful reception strobe |
| rd_req_i | input | 1 | Read request for the timestamp |
| stamp_o | output | 16 | Live counter value |
| rd_stamp_o | output | 16 | Count sampled at the last read request |
| cap_stamp_o | output | 16 | Count sampled at the last successful reception |
| cap_valid_o | output | 1 | One-cycle strobe that a new captured value is present |

## Verification
If the prescaler phase is wrong, the count advances on the wrong tick, and `stamp_o` shows this at the first divided tick after the fault, at most eight ticks later. A phase that is not cleared on a select change shows up as an early or late advance within the next N ticks. A wrong count shows at once on `stamp_o`, and at the next capture or read it also shows on the sampled outputs. A capture that takes the post-increment value differs by one in the cycle after a reception that coincides with an advance. The wrap and the restart rule are driven on purpose so that these cycles occur.

// File: rtl/bit_stamp_pkg.sv
package bit_stamp_pkg;

    localparam int STAMP_W = 16;
    localparam int SEL_W   = 2;
    localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
    localparam int PHASE_W = $clog2(MAX_DIV);

    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [SEL_W-1:0] {
        DIV_BY_1 = 2'b00,
        DIV_BY_2 = 2'b01,
        DIV_BY_4 = 2'b10,
        DIV_BY_8 = 2'b11
    } div_sel_e;

    typedef struct packed {
        stamp_t value;
        logic   fresh;
    } sample_t;

    function automatic phase_t last_phase(input div_sel_e sel);
        phase_t span;
        span = phase_t'((1 << sel) - 1);
        return span;
    endfunction

endpackage

// File: rtl/bit_stamp_prescaler.sv
module bit_stamp_prescaler
    import bit_stamp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick_i,
    input  div_sel_e sel_i,
    output logic     adv_o
);
    phase_t   phase_q;
    div_sel_e sel_q;
    logic     sel_moved;
    logic     at_end;

    assign sel_moved = (sel_i != sel_q);
    assign at_end    = (phase_q == last_phase(sel_i));
    assign adv_o     = tick_i && !sel_moved && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            sel_q   <= DIV_BY_1;
        end else begin
            sel_q <= sel_i;
            if (sel_moved) begin
                phase_q <= '0;
            end else if (tick_i) begin
                phase_q <= at_end ? '0 : phase_q + 1'b1;
            end
        end
    end

    // R4
    sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
        sel_moved |=> (phase_q == '0));

    // R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        phase_q <= last_phase(sel_q));

    // R3
    tickless_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !sel_moved) |=> $stable(phase_q));

endmodule

// File: rtl/bit_stamp_counter.sv
module bit_stamp_counter
    import bit_stamp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv_i,
    output stamp_t stamp_o
);
    stamp_t stamp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stamp_q <= '0;
        end else if (adv_i) begin
            stamp_q <= stamp_q + 1'b1;
        end
    end

    assign stamp_o = stamp_q;

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(stamp_q));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && stamp_q != '1) |=> (stamp_q == stamp_t'($past(stamp_q) + 1'b1)));

    // R5
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && stamp_q == '1) |=> (stamp_q == '0));

endmodule

// File: rtl/bit_stamp_sampler.sv
module bit_stamp_sampler
    import bit_stamp_pkg::*;
#(
    parameter bit PULSE_FRESH = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    take_i,
    input  stamp_t  stamp_i,
    output sample_t sample_o
);
    sample_t smp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q <= '0;
        end else begin
            if (take_i) begin
                smp_q.value <= stamp_i;
            end
            smp_q.fresh <= take_i;
        end
    end

    generate
        if (PULSE_FRESH) begin : g_pulse
            assign sample_o = smp_q;
        end else begin : g_plain
            assign sample_o = '{value: smp_q.value, fresh: 1'b0};
        end
    endgenerate

    // R6
    take_value_chk: assert property (@(posedge clk) disable iff (rst)
        take_i |=> (smp_q.value == $past(stamp_i)));

    // R7
    keep_value_chk: assert property (@(posedge clk) disable iff (rst)
        !take_i |=> ($stable(smp_q.value) && !smp_q.fresh));

endmodule

// File: rtl/bit_stamp_top.sv
module bit_stamp_top
    import bit_stamp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_tick_i,
    input  logic [SEL_W-1:0]   div_sel_i,
    input  logic               rx_ok_i,
    input  logic               rd_req_i,
    output logic [STAMP_W-1:0] stamp_o,
    output logic [STAMP_W-1:0] rd_stamp_o,
    output logic [STAMP_W-1:0] cap_stamp_o,
    output logic               cap_valid_o
);
    div_sel_e sel;
    logic     adv;
    stamp_t   stamp;
    sample_t  cap_smp;
    sample_t  rd_smp;

    assign sel = div_sel_e'(div_sel_i);

    bit_stamp_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (bit_tick_i),
        .sel_i  (sel),
        .adv_o  (adv)
    );

    bit_stamp_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .adv_i   (adv),
        .stamp_o (stamp)
    );

    bit_stamp_sampler #(.PULSE_FRESH(1'b1)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .take_i   (rx_ok_i),
        .stamp_i  (stamp),
        .sample_o (cap_smp)
    );

    bit_stamp_sampler #(.PULSE_FRESH(1'b0)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .take_i   (rd_req_i),
        .stamp_i  (stamp),
        .sample_o (rd_smp)
    );

    assign stamp_o     = stamp;
    assign cap_stamp_o = cap_smp.value;
    assign cap_valid_o = cap_smp.fresh;
    assign rd_stamp_o  = rd_smp.value;

    // R8
    cap_pre_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_ok_i && adv) |=> (cap_stamp_o == stamp_t'(stamp_o - 1'b1)));

    // R6
    cap_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_ok_i |=> cap_valid_o);

    // R9
    read_snap_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req_i |=> (rd_stamp_o == $past(stamp_o)));

    // R2
    tick_needed_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick_i |=> $stable(stamp_o));

endmodule

// File: tb/bit_stamp_top_tb.sv
module bit_stamp_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bit_tick_i;
    logic [1:0]  div_sel_i;
    logic        rx_ok_i;
    logic        rd_req_i;
    logic [15:0] stamp_o, rd_stamp_o, cap_stamp_o;
    logic        cap_valid_o;

    int tests = 0;
    int fails = 0;

    logic [15:0] m_cnt, m_cap, m_rd;
    logic        m_vld;
    logic [2:0]  m_pre;
    logic [1:0]  m_selq;
    string       cnt_tag, cap_tag;
    logic        was_rst;

    always #5 clk = ~clk;

    bit_stamp_top u_dut (
        .clk(clk), .rst(rst), .bit_tick_i(bit_tick_i), .div_sel_i(div_sel_i),
        .rx_ok_i(rx_ok_i), .rd_req_i(rd_req_i), .stamp_o(stamp_o),
        .rd_stamp_o(rd_stamp_o), .cap_stamp_o(cap_stamp_o), .cap_valid_o(cap_valid_o)
    );

    function automatic logic [2:0] span_of(input logic [1:0] s);
        return 3'((1 << s) - 1);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic [1:0] s, input logic rx, input logic rd, input logic r);
        logic chg, adv;
        rst = r; bit_tick_i = t; div_sel_i = s; rx_ok_i = rx; rd_req_i = rd;
        was_rst = r;
        if (r) begin
            m_cnt = '0; m_cap = '0; m_rd = '0; m_vld = 1'b0; m_pre = '0; m_selq = '0;
            cnt_tag = "R1"; cap_tag = "R1";
        end else begin
            chg = (s != m_selq);
            adv = t && !chg && (m_pre == span_of(s));
            cnt_tag = chg ? "R4" : (s == 2'b00 ? "R2" : "R3");
            if (adv && m_cnt == 16'hFFFF) cnt_tag = "R5";
            cap_tag = rx ? (adv ? "R8" : "R6") : "R7";
            if (chg) m_pre = '0;
            else if (t) m_pre = (m_pre == span_of(s)) ? 3'd0 : m_pre + 3'd1;
            if (rx) m_cap = m_cnt;
            m_vld = rx;
            if (rd) m_rd = m_cnt;
            if (adv) m_cnt = m_cnt + 16'd1;
            m_selq = s;
        end
        @(negedge clk);
        chk(cnt_tag, stamp_o, m_cnt);
        chk(cap_tag, cap_stamp_o, m_cap);
        chk(was_rst ? "R1" : (rx ? "R6" : "R7"), {15'd0, cap_valid_o}, {15'd0, m_vld});
        chk(was_rst ? "R1" : "R9", rd_stamp_o, m_rd);
    endtask

    initial begin
        logic [1:0] sel;
        void'($urandom(32'd7331));
        for (int i = 0; i < 3; i++) step(1'b1, 2'b10, 1'b1, 1'b1, 1'b1);
        // R2: steady divide by 1, ticks every cycle, then gaps
        for (int i = 0; i < 20; i++) step(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(i[0], 2'b00, i[1], i[2], 1'b0);
        // R3 / R4: each divider with a tick on the select change
        for (int d = 1; d < 4; d++)
            for (int i = 0; i < 24; i++) step(1'b1, 2'(d), i == 5, i == 9, 1'b0);
        // R8: reception on every cycle while ticking
        for (int i = 0; i < 16; i++) step(1'b1, 2'b01, 1'b1, 1'b0, 1'b0);
        // random mix
        sel = 2'b00;
        for (int i = 0; i < 20000; i++) begin
            if ($urandom_range(63) == 0) sel = 2'($urandom_range(3));
            step($urandom_range(1) == 1, sel, $urandom_range(7) == 0,
                 $urandom_range(7) == 0, $urandom_range(4999) == 0);
        end
        // R5: run the counter through its wrap at divide by 1
        step(1'b0, 2'b00, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 65560; i++)
            step(1'b1, 2'b00, i >= 65530, i == 65535, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1900000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule